// File: doc/BRIEF.md
# Event Counter Bank with Overflow Interrupt

This block keeps ten 48-bit event counters for one processor core. Counter 0 advances on every clock and counter 1 advances on every retired instruction. Counters 2 to 9 each count one of 256 per-cycle event pulse lines, chosen by an 8-bit code. A counter advances only when it is enabled and the privilege filter allows it. The filter has one user bit and one kernel bit per counter, and the core's current privilege level picks which of the two applies.

Software reaches everything through a single-cycle register port. A write takes effect at the next clock edge. A read is combinational from the address. Software can load any counter directly. When an increment carries bit 47 from 0 to 1, that counter's overflow status bit is set. If the counter's interrupt enable is also set, the overflow raises a sticky interrupt-active flag. The interrupt pin follows that flag only while the interrupt-mode field selects fast-interrupt delivery. If status reads zero while the flag is set, the interrupt is spurious.

The register port and the event inputs are plain control pins. There is no back-pressure: every write is accepted in the cycle it is presented, and every event pulse is sampled on the edge it is present.

Top module: `perf_counter_bank`

## Requirements
- R1: Addresses 0 to 9 select counters 0 to 9. A read returns the 48-bit count zero-extended to 64 bits. A write loads bits 47:0 of the write data, and the new value is visible from the next cycle.
- R2: Counter 0 advances by one on every clock edge where it is allowed. Counter 1 advances on every edge where `instr_ret_i` is high and the counter is allowed. Both ignore the event lines and the select registers.
- R3: Counters 2 to 9 advance when `event_i[code]` is high and the counter is allowed. The code for counter i (2 to 5) sits in the select register at address 12, bits (i-2)*8 +: 8. The code for counter i (6 to 9) sits in the select register at address 13, bits (i-6)*8 +: 8. Both select registers store and return bits 31:0 only.
- R4: The control register is at address 10. Count enables for counters 0 to 7 are bits 15:8, and for counters 8 and 9 are bits 33:32. Interrupt enables for counters 0 to 7 are bits 23:16, and for counters 8 and 9 are bits 45:44. A counter whose count enable is clear holds its value.
- R5: The filter register is at address 11. User bits are 9:0 and kernel bits are 25:16. When `priv_kernel_i` is 1 the kernel bit of a counter applies, and when it is 0 the user bit applies. A counter advances only if the applicable bit is set.
- R6: The status register is at address 14, bits 9:0. An increment that takes bit 47 from 0 to 1 sets that counter's bit. Writing a 1 to a bit clears it, but an overflow in the same cycle keeps the bit set. A wrap from all ones to zero, or a software write, sets no bit.
- R7: Control bit 2 is the interrupt-active flag. It is set by any overflow on a counter whose interrupt enable is set, using the enables held before that edge. It clears only when software writes the control register with bit 2 at 0, and a set in the same cycle wins. Clearing status bits leaves the flag unchanged.
- R8: `irq_o` is high exactly when the active flag is set and control bits 1:0 equal 1 (fast-interrupt delivery). Value 0 means off, and values 2 and 3 also deliver nothing.
- R9: After reset, all counters, enables, filters, select codes, status bits and the active flag are zero, the interrupt mode is off, and `irq_o` is low.
- R10: A software write to a counter wins over an increment of that counter in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| csr_wr_i | input | 1 | Register write strobe |
| csr_addr_i | input | 4 | Register address |
| csr_wdata_i | input | 64 | Write data |
| csr_rdata_o | output | 64 | Read data for `csr_addr_i` (combinational) |
| priv_kernel_i | input | 1 | Current privilege level: 1 kernel, 0 user |
| instr_ret_i | input | 1 | Retired-instruction pulse |
| event_i | input | 256 | Per-cycle event pulse lines, indexed by event code |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
Two pairs of functions can land on the same edge. A software load of a counter can coincide with an increment of that counter. A status clear can coincide with a fresh overflow of the same counter.

The bench provokes the first pair by loading counter 0 while it counts every cycle. It provokes the second by loading a counter to just below bit 47 and then issuing the status clear on the very edge its event pulse carries it over. In both cases the bench judges the result against a cycle-level model built from the requirements: the loaded value must appear exactly, not one higher, and the status bit must survive the clear.

A randomized sweep also covers every event code across the eight selectable counters, together with random enables, filters and privilege levels.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int NUM_CNT   = 10;
  localparam int LO_RUN    = 8;
  localparam int HI_RUN    = NUM_CNT - LO_RUN;
  localparam int DATA_W    = 64;
  localparam int ADDR_W    = 4;
  localparam int LANE_W    = 8;
  localparam int NUM_EVT   = 2 ** LANE_W;
  localparam int FIRST_SEL = 2;
  localparam int SEL_LANES = 4;
  localparam int SEL_W     = SEL_LANES * LANE_W;

  localparam logic [ADDR_W-1:0] A_CTRL = 4'd10;
  localparam logic [ADDR_W-1:0] A_FILT = 4'd11;
  localparam logic [ADDR_W-1:0] A_SEL0 = 4'd12;
  localparam logic [ADDR_W-1:0] A_SEL1 = 4'd13;
  localparam logic [ADDR_W-1:0] A_STAT = 4'd14;

  localparam int CTRL_IACT  = 2;
  localparam int CTRL_EN_LO = 8;
  localparam int CTRL_IE_LO = 16;
  localparam int CTRL_EN_HI = 32;
  localparam int CTRL_IE_HI = 44;
  localparam int FILT_KRN   = 16;

  typedef enum logic [1:0] {
    IM_OFF  = 2'd0,
    IM_FAST = 2'd1,
    IM_RSV2 = 2'd2,
    IM_RSV3 = 2'd3
  } imode_e;
endpackage

// File: rtl/pmc_event_sel.sv
module pmc_event_sel
  import pmc_pkg::*;
#(
  parameter int IDX = 2
) (
  input  logic [NUM_EVT-1:0] event_i,
  input  logic               instr_i,
  input  logic [LANE_W-1:0]  code_i,
  output logic               hit_o
);
  generate
    if (IDX == 0) begin : g_cycles
      assign hit_o = 1'b1;
    end else if (IDX == 1) begin : g_instr
      assign hit_o = instr_i;
    end else begin : g_coded
      assign hit_o = event_i[code_i];
    end
  endgenerate
endmodule

// File: rtl/pmc_counter.sv
module pmc_counter #(
  parameter int CNT_W = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam int MSB = CNT_W - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_plus;

  assign cnt_plus = cnt_q + CNT_W'(1);
  assign ovf_o    = inc_i & ~wr_i & ~cnt_q[MSB] & cnt_plus[MSB];
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (wr_i)  cnt_q <= wdata_i;
    else if (inc_i) cnt_q <= cnt_plus;
  end

  p_write_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> cnt_q == $past(wdata_i));
  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !wr_i) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !wr_i) |=> $stable(cnt_q));
  p_ovf_edge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> (cnt_q[MSB] && !$past(cnt_q[MSB])));
endmodule

// File: rtl/pmc_csr.sv
module pmc_csr
  import pmc_pkg::*;
(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  input  logic [NUM_CNT-1:0]            ovf_i,
  output logic [NUM_CNT-1:0]            cnt_en_o,
  output logic [NUM_CNT-1:0]            usr_o,
  output logic [NUM_CNT-1:0]            krn_o,
  output logic [NUM_CNT-1:0][LANE_W-1:0] code_o,
  output logic [DATA_W-1:0]             rdata_o,
  output logic                          irq_o
);
  imode_e             mode_q;
  logic               iact_q;
  logic [NUM_CNT-1:0] en_q, ie_q, usr_q, krn_q, st_q;
  logic [SEL_W-1:0]   sel0_q, sel1_q;

  logic wr_ctrl, wr_filt, wr_sel0, wr_sel1, wr_stat;
  logic iact_set, iact_clr;
  logic [NUM_CNT-1:0] st_clr;

  assign wr_ctrl  = wr_i && (addr_i == A_CTRL);
  assign wr_filt  = wr_i && (addr_i == A_FILT);
  assign wr_sel0  = wr_i && (addr_i == A_SEL0);
  assign wr_sel1  = wr_i && (addr_i == A_SEL1);
  assign wr_stat  = wr_i && (addr_i == A_STAT);
  assign iact_set = |(ovf_i & ie_q);
  assign iact_clr = wr_ctrl & ~wdata_i[CTRL_IACT];
  assign st_clr   = wr_stat ? wdata_i[NUM_CNT-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= IM_OFF;
      en_q   <= '0;
      ie_q   <= '0;
    end else if (wr_ctrl) begin
      mode_q <= imode_e'(wdata_i[1:0]);
      en_q   <= {wdata_i[CTRL_EN_HI +: HI_RUN], wdata_i[CTRL_EN_LO +: LO_RUN]};
      ie_q   <= {wdata_i[CTRL_IE_HI +: HI_RUN], wdata_i[CTRL_IE_LO +: LO_RUN]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) iact_q <= 1'b0;
    else         iact_q <= iact_set | (iact_q & ~iact_clr);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      usr_q <= '0;
      krn_q <= '0;
    end else if (wr_filt) begin
      usr_q <= wdata_i[NUM_CNT-1:0];
      krn_q <= wdata_i[FILT_KRN +: NUM_CNT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel0_q <= '0;
      sel1_q <= '0;
    end else begin
      if (wr_sel0) sel0_q <= wdata_i[SEL_W-1:0];
      if (wr_sel1) sel1_q <= wdata_i[SEL_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= (st_q & ~st_clr) | ovf_i;
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CNT; gi++) begin : g_code
      if (gi < FIRST_SEL) begin : g_fixed
        assign code_o[gi] = '0;
      end else if (gi < FIRST_SEL + SEL_LANES) begin : g_lo
        assign code_o[gi] = sel0_q[(gi - FIRST_SEL) * LANE_W +: LANE_W];
      end else begin : g_hi
        assign code_o[gi] = sel1_q[(gi - FIRST_SEL - SEL_LANES) * LANE_W +: LANE_W];
      end
    end
  endgenerate

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL: begin
        rdata_o[1:0]                    = mode_q;
        rdata_o[CTRL_IACT]              = iact_q;
        rdata_o[CTRL_EN_LO +: LO_RUN]   = en_q[LO_RUN-1:0];
        rdata_o[CTRL_IE_LO +: LO_RUN]   = ie_q[LO_RUN-1:0];
        rdata_o[CTRL_EN_HI +: HI_RUN]   = en_q[NUM_CNT-1:LO_RUN];
        rdata_o[CTRL_IE_HI +: HI_RUN]   = ie_q[NUM_CNT-1:LO_RUN];
      end
      A_FILT: begin
        rdata_o[NUM_CNT-1:0]            = usr_q;
        rdata_o[FILT_KRN +: NUM_CNT]    = krn_q;
      end
      A_SEL0:  rdata_o[SEL_W-1:0]   = sel0_q;
      A_SEL1:  rdata_o[SEL_W-1:0]   = sel1_q;
      A_STAT:  rdata_o[NUM_CNT-1:0] = st_q;
      default: rdata_o = '0;
    endcase
  end

  assign cnt_en_o = en_q;
  assign usr_o    = usr_q;
  assign krn_o    = krn_q;
  assign irq_o    = iact_q && (mode_q == IM_FAST);

  p_iact_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iact_q && !iact_clr) |=> iact_q);
  p_stat_capture_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ovf_i) |=> ((st_q & $past(ovf_i)) == $past(ovf_i)));
  p_stat_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_stat |=> ((st_q & $past(st_q)) == $past(st_q)));
endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
  import pmc_pkg::*;
#(
  parameter int CNT_W = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csr_wr_i,
  input  logic [ADDR_W-1:0] csr_addr_i,
  input  logic [DATA_W-1:0] csr_wdata_i,
  output logic [DATA_W-1:0] csr_rdata_o,
  input  logic              priv_kernel_i,
  input  logic              instr_ret_i,
  input  logic [NUM_EVT-1:0] event_i,
  output logic              irq_o
);
  localparam int PAD_W = DATA_W - CNT_W;

  logic [NUM_CNT-1:0]             cnt_en, usr, krn, hit, inc, ovf, cwr;
  logic [NUM_CNT-1:0][LANE_W-1:0] code;
  logic [NUM_CNT-1:0][CNT_W-1:0]  cnt;
  logic [DATA_W-1:0]              csr_rd;

  pmc_csr u_csr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (csr_wr_i),
    .addr_i   (csr_addr_i),
    .wdata_i  (csr_wdata_i),
    .ovf_i    (ovf),
    .cnt_en_o (cnt_en),
    .usr_o    (usr),
    .krn_o    (krn),
    .code_o   (code),
    .rdata_o  (csr_rd),
    .irq_o    (irq_o)
  );

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
      pmc_event_sel #(.IDX(gi)) u_sel (
        .event_i (event_i),
        .instr_i (instr_ret_i),
        .code_i  (code[gi]),
        .hit_o   (hit[gi])
      );

      assign inc[gi] = cnt_en[gi] & (priv_kernel_i ? krn[gi] : usr[gi]) & hit[gi];
      assign cwr[gi] = csr_wr_i && (csr_addr_i == ADDR_W'(gi));

      pmc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (cwr[gi]),
        .wdata_i (csr_wdata_i[CNT_W-1:0]),
        .inc_i   (inc[gi]),
        .cnt_o   (cnt[gi]),
        .ovf_o   (ovf[gi])
      );
    end
  endgenerate

  always_comb begin
    csr_rdata_o = csr_rd;
    for (int k = 0; k < NUM_CNT; k++) begin
      if (csr_addr_i == ADDR_W'(k)) csr_rdata_o = {{PAD_W{1'b0}}, cnt[k]};
    end
  end

  p_one_write_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cwr));
  p_irq_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(|ovf) || $past(csr_wr_i && csr_addr_i == A_CTRL)));
endmodule

// File: tb/perf_counter_bank_tb_top.sv
module perf_counter_bank_tb_top;
  localparam int W = 48;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr = 1'b0;
  logic [3:0]   addr = '0;
  logic [63:0]  wdata = '0;
  logic [63:0]  rdata;
  logic         priv = 1'b0;
  logic         instr = 1'b0;
  logic [255:0] ev = '0;
  logic         irq;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  logic [W-1:0] m_cnt [10];
  logic [9:0]   m_en = '0, m_ie = '0, m_usr = '0, m_krn = '0, m_st = '0;
  logic [31:0]  m_sel0 = '0, m_sel1 = '0;
  logic [1:0]   m_mode = '0;
  logic         m_iact = 1'b0;

  always #10 clk = ~clk;

  perf_counter_bank dut_i (
    .clk_i(clk), .rst_ni(rst_n), .csr_wr_i(wr), .csr_addr_i(addr),
    .csr_wdata_i(wdata), .csr_rdata_o(rdata), .priv_kernel_i(priv),
    .instr_ret_i(instr), .event_i(ev), .irq_o(irq)
  );

  function automatic logic [7:0] m_code(int i);
    if (i < 6) return m_sel0[(i-2)*8 +: 8];
    return m_sel1[(i-6)*8 +: 8];
  endfunction

  function automatic logic [63:0] m_read(logic [3:0] a);
    if (a < 4'd10) return {16'b0, m_cnt[a]};
    case (a)
      4'd10: return {18'b0, m_ie[9:8], 10'b0, m_en[9:8], 8'b0, m_ie[7:0], m_en[7:0],
                     5'b0, m_iact, m_mode};
      4'd11: return {38'b0, m_krn, 6'b0, m_usr};
      4'd12: return {32'b0, m_sel0};
      4'd13: return {32'b0, m_sel1};
      4'd14: return {54'b0, m_st};
      default: return 64'b0;
    endcase
  endfunction

  // advance the model over one clock edge using the inputs now driven
  task automatic tick();
    logic [W-1:0] nc [10];
    logic [9:0] ovf;
    logic hit, gate, clr;
    ovf = '0;
    for (int i = 0; i < 10; i++) begin
      hit  = (i == 0) ? 1'b1 : (i == 1) ? instr : ev[m_code(i)];
      gate = m_en[i] && (priv ? m_krn[i] : m_usr[i]) && hit;
      nc[i] = m_cnt[i];
      if (wr && addr == 4'(i)) nc[i] = wdata[W-1:0];
      else if (gate) begin
        nc[i] = m_cnt[i] + 1'b1;
        if (!m_cnt[i][W-1] && nc[i][W-1]) ovf[i] = 1'b1;
      end
    end
    @(posedge clk);
    clr = wr && addr == 4'd10 && !wdata[2];
    m_iact = (m_iact && !clr) || |(ovf & m_ie);
    m_st = (m_st & ~((wr && addr == 4'd14) ? wdata[9:0] : 10'b0)) | ovf;
    if (wr && addr == 4'd10) begin
      m_mode = wdata[1:0];
      m_en = {wdata[33:32], wdata[15:8]};
      m_ie = {wdata[45:44], wdata[23:16]};
    end
    if (wr && addr == 4'd11) begin m_usr = wdata[9:0]; m_krn = wdata[25:16]; end
    if (wr && addr == 4'd12) m_sel0 = wdata[31:0];
    if (wr && addr == 4'd13) m_sel1 = wdata[31:0];
    for (int i = 0; i < 10; i++) m_cnt[i] = nc[i];
    @(negedge clk);
  endtask

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(logic [3:0] a, string req);
    wr = 1'b0; addr = a;
    #1;
    check(req, rdata, m_read(a));
    check("R8", {63'b0, irq}, {63'b0, (m_iact && m_mode == 2'd1)});
    tick();
  endtask

  task automatic wrr(logic [3:0] a, logic [63:0] d);
    wr = 1'b1; addr = a; wdata = d;
    tick();
    wr = 1'b0;
  endtask

  function automatic string tag_of(logic [3:0] a);
    if (a < 4'd2) return "R2";
    if (a < 4'd10) return "R3";
    case (a)
      4'd10: return "R4";
      4'd11: return "R5";
      4'd14: return "R6";
      default: return "R3";
    endcase
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 10; i++) m_cnt[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9: reset state of every register and the interrupt pin
    for (int a = 0; a < 15; a++) rd(4'(a), "R9");

    // R1: load and read back a counter
    wrr(4'd5, 64'hFFFF_1234_5678_9ABC);
    rd(4'd5, "R1");

    // R10: write to counter 0 while it counts every cycle
    wrr(4'd11, 64'h0000_0000_0000_03FF);
    wrr(4'd10, 64'h0000_0000_0000_0100);
    rd(4'd0, "R2");
    wrr(4'd0, 64'h123);
    rd(4'd0, "R10");

    // R6/R7/R8: overflow of counter 3 on event 0x55
    wrr(4'd12, 64'h0000_0000_0000_5500);
    wrr(4'd10, 64'h0000_0000_0008_0809);
    wrr(4'd3, 64'h7FFF_FFFF_FFFF);
    ev[8'h55] = 1'b1; tick(); ev = '0;
    rd(4'd14, "R6");
    rd(4'd10, "R7");
    // R6: status clear in the same cycle as a new overflow keeps the bit
    wrr(4'd3, 64'h7FFF_FFFF_FFFF);
    ev[8'h55] = 1'b1; wrr(4'd14, 64'h8); ev = '0;
    rd(4'd14, "R6");
    // R7: clearing status leaves the active flag set (spurious view)
    wrr(4'd14, 64'h3FF);
    rd(4'd14, "R7");
    rd(4'd10, "R7");
    // R8: reserved mode delivers nothing, then fast mode, then flag cleared
    wrr(4'd10, 64'h0000_0000_0008_080F);
    rd(4'd10, "R8");
    wrr(4'd10, 64'h0000_0000_0008_080D);
    rd(4'd10, "R8");
    wrr(4'd10, 64'h0000_0000_0008_0809);
    rd(4'd10, "R7");
    // R6: wrap to zero and software write of bit 47 set no status
    wrr(4'd3, 64'hFFFF_FFFF_FFFF);
    ev[8'h55] = 1'b1; tick(); ev = '0;
    rd(4'd3, "R6");
    wrr(4'd4, 64'h8000_0000_0000);
    rd(4'd14, "R6");

    // sweep: every event code over the selectable counters
    for (int r = 0; r < 40; r++) begin
      logic [31:0] s0, s1;
      for (int k = 0; k < 4; k++) begin
        s0[k*8 +: 8] = 8'((r % 32) * 8 + k);
        s1[k*8 +: 8] = 8'((r % 32) * 8 + 4 + k);
      end
      wrr(4'd12, {$urandom, s0});
      wrr(4'd13, {$urandom, s1});
      wrr(4'd11, {$urandom, $urandom});
      wrr(4'd10, {$urandom, $urandom});
      if (r % 5 == 0) wrr(4'd14, {$urandom, $urandom});
      for (int t = 0; t < 12; t++) begin
        for (int k = 0; k < 8; k++) ev[k*32 +: 32] = $urandom;
        priv = 1'($urandom);
        instr = 1'($urandom);
        tick();
      end
      for (int a = 0; a < 15; a++) rd(4'(a), tag_of(4'(a)));
    end
    ev = '0; instr = 1'b0;
    finish_run();
  end
endmodule